// File: doc/BRIEF.md
# Transactional Pause-and-Resume Warp Stack

This block is the per-warp reconvergence stack of a SIMT core, widened so that it can run hardware transactions. A transaction opens with two entries: a bottom retry record, whose mask gathers the threads that must run again, and a transaction group holding the threads that are running now. Each entry keeps a program counter, a thread mask and a saved log index.

When the core sees that a transactional load or store of some threads touches addresses that a committing transaction already holds, it asks the stack to park those threads. The stack does not abort them. It splits the running group in two: the parked threads go into a lower transaction entry that stores the current log pointer, and the rest stay on top and go on to commit. Each commit attempt ORs the threads that failed validation into the retry record and pops the top group. The next parked group then comes to the top, and its saved log index tells the core where to rewind the log pointer. The log holds a slot for every thread of the warp, inactive ones included, so rewinding the pointer is all that is needed to recover the log state.

Once only the retry record is left under the popped group, the stack does one of two things in the same cycle. If some threads failed, it turns their mask into a fresh group at the transaction start. If none failed, it empties itself and flags that the transaction is done.

Top module: `txn_pause_stack`

## Requirements
- R1: After reset the stack is empty: `stackDepth` is 0, `topValid` is 0, `topPc`/`topMask`/`topLog` are 0 and all three event flags are low.
- R2: `txBegin` on an empty stack gives depth 2, with a top group of `txPc`, `txMask` and log index 0. `txBegin` on a non-empty stack has no effect.
- R3: A pause whose conflict set (`pauseMask` AND top mask) is neither empty nor equal to the top mask adds one entry. The new top holds the remaining threads at `pausePc` with log `logPtrIn`, and the entry below it holds the conflict set with the same PC and log.
- R4: A commit that leaves a transaction group below the popped one reduces depth by 1. The lower group becomes the top, and `topLog` shows the log index it stored when it was parked.
- R5: Failed threads (top mask AND NOT `passMask`) accumulate in the retry record. When a commit uncovers the retry record with a nonzero accumulated mask, the top becomes a group at the transaction start PC with that mask and log 0, the retry mask is cleared, and depth stays 2.
- R6: When a commit uncovers the retry record with a zero accumulated mask, the stack becomes empty and `txDone` is high for exactly one cycle. Commits on an empty stack are ignored.
- R7: A pause with an empty conflict set changes nothing. A pause whose conflict set equals the whole top mask changes nothing and raises `pauseReject` for one cycle.
- R8: A splitting pause on a full stack (depth = `DEPTH`) changes nothing and raises `overflow` for one cycle. Depth never exceeds `DEPTH`.
- R9: When `commitValid` and `pauseReq` are high in the same cycle, the commit is carried out and the pause is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Open a transaction |
| txPc | input | PCW | Transaction start PC |
| txMask | input | WARP | Threads entering the transaction |
| pauseReq | input | 1 | Park conflicting threads of the top group |
| pauseMask | input | WARP | Threads flagged as conflicting |
| pausePc | input | PCW | PC of the conflicting memory instruction |
| logPtrIn | input | LGW | Current transactional log pointer |
| commitValid | input | 1 | Top group has a commit outcome |
| passMask | input | WARP | Threads that passed validation |
| topValid | output | 1 | Stack holds a running group |
| topPc | output | PCW | PC of the top group |
| topMask | output | WARP | Active mask of the top group |
| topLog | output | LGW | Log index to restore for the top group |
| stackDepth | output | SPW | Number of occupied entries |
| txDone | output | 1 | One-cycle pulse: transaction fully committed |
| pauseReject | output | 1 | One-cycle pulse: pause would park every thread |
| overflow | output | 1 | One-cycle pulse: split refused, stack full |

## Verification
A commit outcome and a pause request can reach the stack in the same cycle, because the conflict check of one instruction may finish while the group on top is resolving its commit. The bench raises both strobes together in the cycle where the commit finishes the transaction, with a pause mask that would split the group if it were carried out. The outcome is judged by an empty stack and a `txDone` pulse, not a deeper stack. A checker also follows every cycle where both strobes arrive on a stack deeper than 2 and requires the depth to drop by exactly one.

// File: rtl/txn_pause_stack_pkg.sv
package txn_pause_stack_pkg;
  // One-hot strobes from control to datapath; at most one stack operation per cycle.
  typedef struct packed {
    logic open;     // push retry record plus first group
    logic split;    // park conflict set below the remaining threads
    logic pop;      // pop a group, uncovering a parked group
    logic restart;  // retry record uncovered with failures: refill the group
    logic finish;   // retry record uncovered clean: empty the stack
    logic reject;   // pause would park every thread
    logic ovf;      // split refused on a full stack
  } stackOp_t;
endpackage

// File: rtl/txn_pause_stack_ctrl.sv
module txn_pause_stack_ctrl
  import txn_pause_stack_pkg::*;
(
  input  logic     txBegin,
  input  logic     pauseReq,
  input  logic     commitValid,
  input  logic     isEmpty,
  input  logic     isFull,
  input  logic     nextIsRetry,
  input  logic     mergedZero,
  input  logic     conflictNone,
  input  logic     conflictAll,
  output stackOp_t op
);
  logic doCommit, doPause, wantSplit;

  always_comb begin
    doCommit  = commitValid && !isEmpty;
    // a commit in the same cycle takes the slot; the pause is dropped
    doPause   = pauseReq && !isEmpty && !commitValid;
    wantSplit = doPause && !conflictNone && !conflictAll;

    op         = '0;
    op.open    = txBegin && isEmpty;
    op.pop     = doCommit && !nextIsRetry;
    op.restart = doCommit && nextIsRetry && !mergedZero;
    op.finish  = doCommit && nextIsRetry && mergedZero;
    op.split   = wantSplit && !isFull;
    op.ovf     = wantSplit && isFull;
    op.reject  = doPause && conflictAll;
  end
endmodule

// File: rtl/txn_pause_stack_data.sv
module txn_pause_stack_data
  import txn_pause_stack_pkg::*;
#(
  parameter int WARP  = 8,
  parameter int PCW   = 16,
  parameter int LGW   = 8,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  stackOp_t        op,
  input  logic [PCW-1:0]  txPc,
  input  logic [WARP-1:0] txMask,
  input  logic [PCW-1:0]  pausePc,
  input  logic [WARP-1:0] pauseMask,
  input  logic [LGW-1:0]  logPtrIn,
  input  logic [WARP-1:0] passMask,
  output logic            isEmpty,
  output logic            isFull,
  output logic            nextIsRetry,
  output logic            mergedZero,
  output logic            conflictNone,
  output logic            conflictAll,
  output logic            topValid,
  output logic [PCW-1:0]  topPc,
  output logic [WARP-1:0] topMask,
  output logic [LGW-1:0]  topLog,
  output logic [SPW-1:0]  stackDepth,
  output logic            txDone,
  output logic            pauseReject,
  output logic            overflow
);
  // Entry 0 is always the retry record while a transaction is open.
  logic [PCW-1:0]  pcMem   [DEPTH];
  logic [WARP-1:0] maskMem [DEPTH];
  logic [LGW-1:0]  logMem  [DEPTH];
  logic [SPW-1:0]  sp;
  logic [IW-1:0]   topIdx, pushIdx;
  logic [WARP-1:0] curMask, conflict, merged;
  logic            doneQ, rejectQ, ovfQ;

  always_comb begin
    topIdx       = IW'(sp - SPW'(1));
    pushIdx      = IW'(sp);
    isEmpty      = (sp == '0);
    isFull       = (sp == SPW'(DEPTH));
    nextIsRetry  = (sp == SPW'(2));
    curMask      = isEmpty ? '0 : maskMem[topIdx];
    conflict     = pauseMask & curMask;
    conflictNone = (conflict == '0);
    conflictAll  = !conflictNone && (conflict == curMask);
    merged       = maskMem[0] | (curMask & ~passMask);
    mergedZero   = (merged == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp      <= '0;
      doneQ   <= 1'b0;
      rejectQ <= 1'b0;
      ovfQ    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        pcMem[i]   <= '0;
        maskMem[i] <= '0;
        logMem[i]  <= '0;
      end
    end else begin
      doneQ   <= op.finish;
      rejectQ <= op.reject;
      ovfQ    <= op.ovf;
      if (op.open) begin
        pcMem[0]   <= txPc;
        maskMem[0] <= '0;
        logMem[0]  <= '0;
        pcMem[1]   <= txPc;
        maskMem[1] <= txMask;
        logMem[1]  <= '0;
        sp         <= SPW'(2);
      end
      if (op.split) begin
        maskMem[topIdx]  <= conflict;
        pcMem[topIdx]    <= pausePc;
        logMem[topIdx]   <= logPtrIn;
        maskMem[pushIdx] <= curMask & ~conflict;
        pcMem[pushIdx]   <= pausePc;
        logMem[pushIdx]  <= logPtrIn;
        sp               <= sp + SPW'(1);
      end
      if (op.pop) begin
        maskMem[0] <= merged;
        sp         <= sp - SPW'(1);
      end
      if (op.restart) begin
        maskMem[0] <= '0;
        maskMem[1] <= merged;
        pcMem[1]   <= pcMem[0];
        logMem[1]  <= '0;
      end
      if (op.finish) begin
        maskMem[0] <= '0;
        sp         <= '0;
      end
    end
  end

  assign topValid    = !isEmpty;
  assign topPc       = isEmpty ? '0 : pcMem[topIdx];
  assign topMask     = curMask;
  assign topLog      = isEmpty ? '0 : logMem[topIdx];
  assign stackDepth  = sp;
  assign txDone      = doneQ;
  assign pauseReject = rejectQ;
  assign overflow    = ovfQ;
endmodule

// File: rtl/txn_pause_stack.sv
module txn_pause_stack
  import txn_pause_stack_pkg::*;
#(
  parameter int WARP  = 8,
  parameter int PCW   = 16,
  parameter int LGW   = 8,
  parameter int DEPTH = 8,   // at least 8
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            txBegin,
  input  logic [PCW-1:0]  txPc,
  input  logic [WARP-1:0] txMask,
  input  logic            pauseReq,
  input  logic [WARP-1:0] pauseMask,
  input  logic [PCW-1:0]  pausePc,
  input  logic [LGW-1:0]  logPtrIn,
  input  logic            commitValid,
  input  logic [WARP-1:0] passMask,
  output logic            topValid,
  output logic [PCW-1:0]  topPc,
  output logic [WARP-1:0] topMask,
  output logic [LGW-1:0]  topLog,
  output logic [SPW-1:0]  stackDepth,
  output logic            txDone,
  output logic            pauseReject,
  output logic            overflow
);
  stackOp_t op;
  logic isEmpty, isFull, nextIsRetry, mergedZero, conflictNone, conflictAll;

  txn_pause_stack_ctrl u_ctrl (
    .txBegin(txBegin), .pauseReq(pauseReq), .commitValid(commitValid),
    .isEmpty(isEmpty), .isFull(isFull), .nextIsRetry(nextIsRetry),
    .mergedZero(mergedZero), .conflictNone(conflictNone),
    .conflictAll(conflictAll), .op(op)
  );

  txn_pause_stack_data #(.WARP(WARP), .PCW(PCW), .LGW(LGW), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .op(op),
    .txPc(txPc), .txMask(txMask), .pausePc(pausePc), .pauseMask(pauseMask),
    .logPtrIn(logPtrIn), .passMask(passMask),
    .isEmpty(isEmpty), .isFull(isFull), .nextIsRetry(nextIsRetry),
    .mergedZero(mergedZero), .conflictNone(conflictNone), .conflictAll(conflictAll),
    .topValid(topValid), .topPc(topPc), .topMask(topMask), .topLog(topLog),
    .stackDepth(stackDepth), .txDone(txDone), .pauseReject(pauseReject),
    .overflow(overflow)
  );
endmodule

// File: rtl/txn_pause_stack_chk.sv
module txn_pause_stack_chk #(
  parameter int WARP  = 8,
  parameter int DEPTH = 8,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            pauseReq,
  input logic            commitValid,
  input logic            topValid,
  input logic [WARP-1:0] topMask,
  input logic [SPW-1:0]  stackDepth,
  input logic            txDone,
  input logic            pauseReject,
  input logic            overflow
);
  // R2
  no_lone_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth != SPW'(1));

  // R6
  done_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (stackDepth == '0) && !topValid);

  // R7
  reject_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseReject |-> $stable(topMask) && $stable(stackDepth));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= SPW'(DEPTH));

  // R8
  ovf_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (stackDepth == SPW'(DEPTH)) && $stable(stackDepth));

  // R9
  commit_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && pauseReq && stackDepth > SPW'(2)) |=>
      stackDepth == $past(stackDepth) - SPW'(1));
endmodule

bind txn_pause_stack txn_pause_stack_chk #(.WARP(WARP), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .pauseReq(pauseReq), .commitValid(commitValid),
  .topValid(topValid), .topMask(topMask), .stackDepth(stackDepth),
  .txDone(txDone), .pauseReject(pauseReject), .overflow(overflow)
);

// File: tb/txn_pause_stack_bench.sv
module txn_pause_stack_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        txBegin = 0, pauseReq = 0, commitValid = 0;
  logic [15:0] txPc = 0, pausePc = 0, topPc;
  logic [7:0]  txMask = 0, pauseMask = 0, passMask = 0, logPtrIn = 0, topMask, topLog;
  logic [3:0]  stackDepth;
  logic        topValid, txDone, pauseReject, overflow;

  txn_pause_stack u_txn_pause_stack (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txPc(txPc), .txMask(txMask),
    .pauseReq(pauseReq), .pauseMask(pauseMask), .pausePc(pausePc), .logPtrIn(logPtrIn),
    .commitValid(commitValid), .passMask(passMask),
    .topValid(topValid), .topPc(topPc), .topMask(topMask), .topLog(topLog),
    .stackDepth(stackDepth), .txDone(txDone), .pauseReject(pauseReject), .overflow(overflow)
  );

  int total = 0, failed = 0;

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // b p c : begin / pause / commit strobes; msk serves txMask or pauseMask
  typedef struct packed {
    logic b; logic p; logic c;
    logic [7:0] msk; logic [15:0] pc; logic [7:0] lg; logic [7:0] pass;
    logic ev; logic [15:0] epc; logic [7:0] em; logic [7:0] el; logic [3:0] ed;
    logic edn; logic erj; logic eov; logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1,0,0, 8'hFF,16'h100,8'h00,8'h00, 1,16'h100,8'hFF,8'h00,4'd2, 0,0,0, 4'd2}, // R2 open
    '{1,0,0, 8'h0F,16'h200,8'h00,8'h00, 1,16'h100,8'hFF,8'h00,4'd2, 0,0,0, 4'd2}, // R2 open while busy ignored
    '{0,1,0, 8'h0F,16'h110,8'h05,8'h00, 1,16'h110,8'hF0,8'h05,4'd3, 0,0,0, 4'd3}, // R3 split
    '{0,1,0, 8'h00,16'h120,8'h09,8'h00, 1,16'h110,8'hF0,8'h05,4'd3, 0,0,0, 4'd7}, // R7 empty conflict
    '{0,1,0, 8'hF0,16'h120,8'h09,8'h00, 1,16'h110,8'hF0,8'h05,4'd3, 0,1,0, 4'd7}, // R7 whole mask
    '{0,1,0, 8'h30,16'h130,8'h0A,8'h00, 1,16'h130,8'hC0,8'h0A,4'd4, 0,0,0, 4'd3}, // R3 second split
    '{0,0,1, 8'h00,16'h000,8'h00,8'h40, 1,16'h130,8'h30,8'h0A,4'd3, 0,0,0, 4'd4}, // R4 resume parked
    '{0,0,1, 8'h00,16'h000,8'h00,8'h30, 1,16'h110,8'h0F,8'h05,4'd2, 0,0,0, 4'd4}, // R4 resume first parked
    '{0,0,1, 8'h00,16'h000,8'h00,8'h09, 1,16'h100,8'h86,8'h00,4'd2, 0,0,0, 4'd5}, // R5 retry refill
    '{0,1,1, 8'h02,16'h140,8'h0B,8'h86, 0,16'h000,8'h00,8'h00,4'd0, 1,0,0, 4'd9}, // R9 commit beats pause
    '{0,0,0, 8'h00,16'h000,8'h00,8'h00, 0,16'h000,8'h00,8'h00,4'd0, 0,0,0, 4'd6}, // R6 pulse ends
    '{0,0,1, 8'h00,16'h000,8'h00,8'h00, 0,16'h000,8'h00,8'h00,4'd0, 0,0,0, 4'd6}, // R6 commit on empty
    '{1,0,0, 8'hFF,16'h300,8'h00,8'h00, 1,16'h300,8'hFF,8'h00,4'd2, 0,0,0, 4'd2}, // R2
    '{0,1,0, 8'h01,16'h310,8'h01,8'h00, 1,16'h310,8'hFE,8'h01,4'd3, 0,0,0, 4'd8}, // R8 fill
    '{0,1,0, 8'h02,16'h310,8'h02,8'h00, 1,16'h310,8'hFC,8'h02,4'd4, 0,0,0, 4'd8},
    '{0,1,0, 8'h04,16'h310,8'h03,8'h00, 1,16'h310,8'hF8,8'h03,4'd5, 0,0,0, 4'd8},
    '{0,1,0, 8'h08,16'h310,8'h04,8'h00, 1,16'h310,8'hF0,8'h04,4'd6, 0,0,0, 4'd8},
    '{0,1,0, 8'h10,16'h310,8'h05,8'h00, 1,16'h310,8'hE0,8'h05,4'd7, 0,0,0, 4'd8},
    '{0,1,0, 8'h20,16'h310,8'h06,8'h00, 1,16'h310,8'hC0,8'h06,4'd8, 0,0,0, 4'd8},
    '{0,1,0, 8'h40,16'h320,8'h07,8'h00, 1,16'h310,8'hC0,8'h06,4'd8, 0,0,1, 4'd8}, // R8 overflow
    '{0,0,0, 8'h00,16'h000,8'h00,8'h00, 1,16'h310,8'hC0,8'h06,4'd8, 0,0,0, 4'd8}, // R8 pulse ends
    '{0,0,1, 8'h00,16'h000,8'h00,8'hC0, 1,16'h310,8'h20,8'h06,4'd7, 0,0,0, 4'd4}  // R4 from full
  };

  task automatic checkReset();
    chk(1, "topValid", 32'(topValid), 0);
    chk(1, "depth", 32'(stackDepth), 0);
    chk(1, "topPc", 32'(topPc), 0);
    chk(1, "topMask", 32'(topMask), 0);
    chk(1, "topLog", 32'(topLog), 0);
    chk(1, "flags", {29'd0, txDone, pauseReject, overflow}, 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkReset();                 // R1 after power-up reset
    rstN = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      txBegin = VEC[i].b; pauseReq = VEC[i].p; commitValid = VEC[i].c;
      txMask = VEC[i].msk; pauseMask = VEC[i].msk;
      txPc = VEC[i].pc; pausePc = VEC[i].pc; logPtrIn = VEC[i].lg;
      passMask = VEC[i].pass;
      @(negedge clk);
      txBegin = 0; pauseReq = 0; commitValid = 0;
      chk(int'(VEC[i].req), $sformatf("row%0d topValid", i), 32'(topValid), 32'(VEC[i].ev));
      chk(int'(VEC[i].req), $sformatf("row%0d topPc", i), 32'(topPc), 32'(VEC[i].epc));
      chk(int'(VEC[i].req), $sformatf("row%0d topMask", i), 32'(topMask), 32'(VEC[i].em));
      chk(int'(VEC[i].req), $sformatf("row%0d topLog", i), 32'(topLog), 32'(VEC[i].el));
      chk(int'(VEC[i].req), $sformatf("row%0d depth", i), 32'(stackDepth), 32'(VEC[i].ed));
      chk(int'(VEC[i].req), $sformatf("row%0d txDone", i), 32'(txDone), 32'(VEC[i].edn));
      chk(int'(VEC[i].req), $sformatf("row%0d pauseReject", i), 32'(pauseReject), 32'(VEC[i].erj));
      chk(int'(VEC[i].req), $sformatf("row%0d overflow", i), 32'(overflow), 32'(VEC[i].eov));
    end
    // R1: reset in the middle of a deep transaction empties the stack
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    rstN = 1'b1;
    // R2: a new transaction opens cleanly after reset
    txBegin = 1; txPc = 16'h500; txMask = 8'h3C;
    @(negedge clk);
    txBegin = 0;
    chk(2, "reopen topPc", 32'(topPc), 32'h500);
    chk(2, "reopen topMask", 32'(topMask), 32'h3C);
    chk(2, "reopen depth", 32'(stackDepth), 2);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule